// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned words one bit per clock, least significant bit first. It uses two right-shifting registers, one full adder and one carry flip-flop. The accumulator register holds the running value. The operand register holds the value to be added. On every busy clock the low bits of both registers and the stored carry pass through the full adder. The sum bit enters the accumulator from the top, in the slot that the shift has just freed. After `N` shifts the accumulator holds the sum, so no third register is needed.

The operand register feeds its own low bit back to its top while an addition runs. Its contents are therefore back in place when the addition ends. A new operand can be loaded and a further pass started to build a running total. The operand can be written in parallel, or shifted in one bit at a time.

Each pass starts with the carry cleared. The carry out of each pass is collected in a sticky flag instead of being added into the next pass.

The edge of the block is plain control. Loads and `start` are single-cycle strobes. There is no ready signal: while a pass is running, these strobes are dropped. A caller that needs to know when the block is free waits for `done`, which comes exactly `N` cycles after an accepted `start`. Back-pressure is therefore expressed by timing, not by a handshake.

Top module: `bitser_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the operand register, the carry, the sticky carry flag and `done`. It also ends any pass in progress.
- R2: When idle, `a_load` high at an edge writes `a_din` into the accumulator. The new value appears on `a_q` after that edge.
- R3: When idle, `b_load` high at an edge writes `b_din` into the operand register. When idle with `b_load` low, `b_ser_en` high shifts the operand register right and places `b_ser_in` in bit N-1. After four serial bits s0,s1,s2,s3 (in that order) the register holds {s3,s2,s1,s0}. If both strobes are high, `b_load` wins.
- R4: A `start` accepted at edge k makes the block busy. It shifts at edges k+1 through k+N. `done` is high for exactly the one cycle that follows edge k+N.
- R5: When `done` is high, `a_q` equals (accumulator + operand) modulo 2^N, using the values the registers held when the pass began.
- R6: For N=4, adding 1011 and 1001 leaves 0100 in the accumulator and sets `carry_out` to 1.
- R7: The operand register holds the same value after a pass as before it. A second `start` with no reload adds the same operand again.
- R8: The carry flip-flop is cleared when a pass starts. A carry left from an earlier pass is never added into a later one.
- R9: `carry_out` is set when any pass since the last accepted accumulator load (or reset) produced a carry out of bit N-1. It is cleared by an accepted `a_load`.
- R10: While a pass is running, `a_load`, `b_load`, `b_ser_en` and `start` have no effect. The result, the operand and the timing of `done` do not change.
- R11: When `start` is accepted in the same cycle as `a_load` and/or `b_load`, the loads take effect first and the pass adds the newly loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_load | input | 1 | Write `a_din` into the accumulator (idle only) |
| a_din | input | N | Parallel value for the accumulator |
| b_load | input | 1 | Write `b_din` into the operand register (idle only) |
| b_din | input | N | Parallel value for the operand register |
| b_ser_en | input | 1 | Shift `b_ser_in` into the operand register's top bit (idle only) |
| b_ser_in | input | 1 | Serial bit for the operand register |
| start | input | 1 | Begin one N-cycle addition pass (dropped while busy) |
| a_q | output | N | Accumulator contents |
| done | output | 1 | One-cycle pulse after the last shift of a pass |
| carry_out | output | 1 | Sticky carry out since the last accumulator load |

## Verification
The embedded properties check the following on every cycle:
- `done` is a one-cycle pulse that only follows the final count of a busy phase.
- A start that arrives mid-pass neither restarts nor stalls the counter.
- The carry is zero in the first busy cycle.
- When `done` rises, the accumulator equals the modular sum of the snapshot values and the operand equals its own snapshot.
- An accepted accumulator load clears the sticky flag.

Only the bench's scenarios can show the following:
- That the arithmetic matches fixed expected values, including the 1011 + 1001 case.
- That chained passes accumulate.
- That serial loading of the operand produces the stated bit order.
- That strobes given during a pass leave no trace on later passes.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/bsa_sreg.sv
// Right-shifting register with parallel load; load has priority over shift.
module bsa_sreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         sh,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (ld) q_r <= din;
    else if (sh) q_r <= {sin, q_r[W-1:1]};
  end

  assign q    = q_r;
  assign sout = q_r[0];

  // R2/R3: parallel write lands one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(din));
  // R3: a shift moves the serial bit into the top position
  p_shift_top_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && sh) |=> q[W-1] == $past(sin));
  // R10: without a load or shift the register keeps its value
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ld && !sh) |=> $stable(q));
endmodule

// File: rtl/bsa_carry_cell.sv
// Full adder with a registered carry fed back on the next edge.
module bsa_carry_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic x,
  input  logic y,
  output logic s,
  output logic cout,
  output logic cy_q
);
  logic cy_r;

  assign s    = x ^ y ^ cy_r;
  assign cout = (x & y) | (x & cy_r) | (y & cy_r);
  assign cy_q = cy_r;

  always_ff @(posedge clk) begin
    if (rst || clr) cy_r <= 1'b0;
    else if (en)    cy_r <= cout;
  end

  // R8: a clear always leaves the carry at zero
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !cy_q);
  // R10: carry only moves while enabled
  p_cy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(cy_q));
endmodule

// File: rtl/bsa_seq_ctrl.sv
// Pass sequencer: counts N shift cycles and pulses done once.
module bsa_seq_ctrl
  import bsa_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic first,
  output logic last,
  output logic start_ok,
  output logic done
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          done_r;

  assign busy     = (ph == PH_RUN);
  assign first    = busy && (cnt == '0);
  assign last     = busy && (cnt == LAST_CNT);
  assign start_ok = start && !busy;
  assign done     = done_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph  <= PH_RUN;
            cnt <= '0;
          end
        end
        PH_RUN: begin
          if (cnt == LAST_CNT) begin
            ph     <= PH_IDLE;
            done_r <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R4: done lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: done only follows the last counted cycle of a pass
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(cnt) == LAST_CNT));
  // R10: a start during a pass neither restarts nor stalls the count
  p_start_dropped_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cnt != LAST_CNT) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/bitser_accum.sv
module bitser_accum #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_load,
  input  logic [N-1:0] a_din,
  input  logic         b_load,
  input  logic [N-1:0] b_din,
  input  logic         b_ser_en,
  input  logic         b_ser_in,
  input  logic         start,
  output logic [N-1:0] a_q,
  output logic         done,
  output logic         carry_out
);
  logic         busy, first, last, start_ok;
  logic [N-1:0] acc_q, opd_q;
  logic         acc_lsb, opd_lsb;
  logic         sum_bit, cout, cy_q;
  logic         acc_ld, opd_ld, opd_sh, opd_sin;
  logic         sticky;

  assign acc_ld  = a_load && !busy;
  assign opd_ld  = b_load && !busy;
  assign opd_sh  = busy || b_ser_en;
  assign opd_sin = busy ? opd_lsb : b_ser_in;

  bsa_seq_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .first(first), .last(last),
    .start_ok(start_ok), .done(done)
  );

  bsa_sreg #(.W(N)) u_acc (
    .clk(clk), .rst(rst), .ld(acc_ld), .din(a_din),
    .sh(busy), .sin(sum_bit), .q(acc_q), .sout(acc_lsb)
  );

  bsa_sreg #(.W(N)) u_opd (
    .clk(clk), .rst(rst), .ld(opd_ld), .din(b_din),
    .sh(opd_sh), .sin(opd_sin), .q(opd_q), .sout(opd_lsb)
  );

  bsa_carry_cell u_fa (
    .clk(clk), .rst(rst), .clr(start_ok), .en(busy),
    .x(acc_lsb), .y(opd_lsb), .s(sum_bit), .cout(cout), .cy_q(cy_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                  sticky <= 1'b0;
    else if (acc_ld)          sticky <= 1'b0;
    else if (last && cout)    sticky <= 1'b1;
  end

  assign a_q       = acc_q;
  assign carry_out = sticky;

  // Snapshots of the operands as a pass begins, for the checks below.
  logic [N-1:0] a_snap, b_snap;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_snap <= '0;
      b_snap <= '0;
    end else if (first) begin
      a_snap <= acc_q;
      b_snap <= opd_q;
    end
  end

  // R8: each pass begins with a zero carry
  p_cy_clear_r8: assert property (@(posedge clk) disable iff (rst)
    first |-> !cy_q);
  // R5: the finished accumulator is the modular sum of the pass inputs
  p_sum_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> a_q == N'(a_snap + b_snap));
  // R7: the operand has circulated back into place
  p_restore_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> opd_q == b_snap);
  // R9: an accepted accumulator load clears the sticky carry
  p_sticky_clr_r9: assert property (@(posedge clk) disable iff (rst)
    acc_ld |=> !carry_out);
  // R9: the sticky carry never drops except through a load
  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (carry_out && !acc_ld) |=> carry_out);
endmodule

// File: tb/sim_bitser_accum.sv
`timescale 1ns/1ps
module sim_bitser_accum;
  localparam int N = 4;
  localparam int NV = 6;
  // a, b, d, a+b, carry after first pass, a+b+d, sticky carry after second pass
  localparam logic [21:0] VEC [NV] = '{
    {4'hB, 4'h9, 4'h3, 4'h4, 1'b1, 4'h7, 1'b1},
    {4'h2, 4'h3, 4'hA, 4'h5, 1'b0, 4'hF, 1'b0},
    {4'hF, 4'h1, 4'hF, 4'h0, 1'b1, 4'hF, 1'b1},
    {4'h7, 4'h8, 4'h1, 4'hF, 1'b0, 4'h0, 1'b1},
    {4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0},
    {4'hC, 4'hC, 4'h8, 4'h8, 1'b1, 4'h0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a_load = 1'b0, b_load = 1'b0, b_ser_en = 1'b0, b_ser_in = 1'b0, start = 1'b0;
  logic [N-1:0] a_din = '0, b_din = '0;
  logic [N-1:0] a_q;
  logic         done, carry_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bitser_accum #(.N(N)) u0 (
    .clk(clk), .rst(rst), .a_load(a_load), .a_din(a_din),
    .b_load(b_load), .b_din(b_din), .b_ser_en(b_ser_en), .b_ser_in(b_ser_in),
    .start(start), .a_q(a_q), .done(done), .carry_out(carry_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_a(input logic [N-1:0] v);
    a_load = 1'b1; a_din = v; step(); a_load = 1'b0;
  endtask

  task automatic load_b(input logic [N-1:0] v);
    b_load = 1'b1; b_din = v; step(); b_load = 1'b0;
  endtask

  // Pulses start (with any loads the caller has raised) and checks done timing.
  task automatic run_add();
    start = 1'b1; step();
    start = 1'b0; a_load = 1'b0; b_load = 1'b0; b_ser_en = 1'b0;
    for (int i = 1; i < N; i++) begin
      step();
      chk(done == 1'b0, "R4 done early", done, 0);
    end
    step();
    chk(done == 1'b1, "R4 done pulse", done, 1);
    step();
    chk(done == 1'b0, "R4 done width", done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk(a_q == '0, "R1 a_q after reset", a_q, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(carry_out == 1'b0, "R1 carry after reset", carry_out, 0);
    // R1: operand reset to zero, so adding it leaves A unchanged
    load_a(4'h9);
    chk(a_q == 4'h9, "R2 parallel load", a_q, 9);
    run_add();
    chk(a_q == 4'h9, "R1 operand cleared", a_q, 9);

    // Vector table: R5, R6 (first entry), R8, R9
    for (int v = 0; v < NV; v++) begin
      load_a(VEC[v][21:18]);
      chk(carry_out == 1'b0, "R9 cleared by load", carry_out, 0);
      load_b(VEC[v][17:14]);
      run_add();
      chk(a_q == VEC[v][9:6], "R5 R6 sum", a_q, VEC[v][9:6]);
      chk(carry_out == VEC[v][5], "R6 R9 carry", carry_out, VEC[v][5]);
      load_b(VEC[v][13:10]);
      run_add();
      chk(a_q == VEC[v][4:1], "R8 accumulate", a_q, VEC[v][4:1]);
      chk(carry_out == VEC[v][0], "R9 sticky carry", carry_out, VEC[v][0]);
    end

    // R7: operand survives a pass
    load_a(4'h1); load_b(4'h2);
    run_add();
    chk(a_q == 4'h3, "R7 first pass", a_q, 3);
    run_add();
    chk(a_q == 4'h5, "R7 operand reused", a_q, 5);

    // R3: serial entry of the operand, bits 1,0,1,1 give 1101
    load_a(4'h0);
    b_ser_en = 1'b1;
    b_ser_in = 1'b1; step();
    b_ser_in = 1'b0; step();
    b_ser_in = 1'b1; step();
    b_ser_in = 1'b1; step();
    b_ser_en = 1'b0; b_ser_in = 1'b0;
    run_add();
    chk(a_q == 4'hD, "R3 serial order", a_q, 13);
    // R3: parallel load wins over serial shift
    load_a(4'h0);
    b_load = 1'b1; b_din = 4'h5; b_ser_en = 1'b1; b_ser_in = 1'b1;
    step();
    b_load = 1'b0; b_ser_en = 1'b0; b_ser_in = 1'b0;
    run_add();
    chk(a_q == 4'h5, "R3 load priority", a_q, 5);

    // R10: strobes during a pass are dropped
    load_a(4'h3); load_b(4'h4);
    start = 1'b1; step(); start = 1'b0;
    step();
    a_load = 1'b1; a_din = 4'hF; b_load = 1'b1; b_din = 4'hF;
    b_ser_en = 1'b1; b_ser_in = 1'b1; start = 1'b1;
    step();
    a_load = 1'b0; b_load = 1'b0; b_ser_en = 1'b0; b_ser_in = 1'b0; start = 1'b0;
    step();
    chk(done == 1'b0, "R10 no early done", done, 0);
    step();
    chk(done == 1'b1, "R10 done on time", done, 1);
    chk(a_q == 4'h7, "R10 result kept", a_q, 7);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(done == 1'b0, "R10 dropped start", done, 0);
    end
    chk(a_q == 4'h7, "R10 accumulator untouched", a_q, 7);
    run_add();
    chk(a_q == 4'hB, "R10 operand untouched", a_q, 11);

    // R11: loads with start in one cycle; carry cleared by that load (R9)
    load_a(4'hF); load_b(4'h1);
    run_add();
    chk(carry_out == 1'b1, "R9 carry set", carry_out, 1);
    a_load = 1'b1; a_din = 4'h6; b_load = 1'b1; b_din = 4'h5;
    run_add();
    chk(a_q == 4'hB, "R11 same-cycle loads", a_q, 11);
    chk(carry_out == 1'b0, "R9 cleared with start", carry_out, 0);

    // R1: reset in the middle of a pass
    load_a(4'h5); load_b(4'h7);
    start = 1'b1; step(); start = 1'b0;
    step(); step();
    rst = 1'b1; step(); rst = 1'b0;
    chk(a_q == '0, "R1 mid-pass reset a_q", a_q, 0);
    chk(carry_out == 1'b0, "R1 mid-pass reset carry", carry_out, 0);
    for (int i = 0; i < N + 2; i++) begin
      step();
      chk(done == 1'b0, "R1 pass aborted", done, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule